// File: doc/BRIEF.md
# Single-Hit Drift-Time Frame Assembler

This block gathers hit results from 32 detector channels over a window of three consecutive bunch crossings and turns them into one fixed-length readout frame. A strobe marks the first clock cycle of each crossing. The first strobe seen while idle opens the window. The next two strobes step the window to the second and third crossings, and the fourth strobe closes it. For every channel, only the earliest hit inside the window is recorded. The record holds the crossing in which the hit arrived and its 6-bit fine drift time, where 64 bins span one 25 ns crossing.

When the window closes, the block captures the header word supplied at that moment. It then offers the header followed by one slot per channel as a single parallel word and holds it with a valid flag until the consumer accepts it. The default slot is 8 bits: a 2-bit crossing code above the drift time, with a reserved code for a channel that saw no hit. A parameter selects a narrower 7-bit slot, which is a single no-hit flag above the drift time and gives a 256-bit frame in place of 288 bits.

Top module: `drift_frame_asm`

## Requirements
- R1: The frame places the header in bits 31..0, and that header is the value present on `header` in the cycle of the window-closing strobe. Channel k occupies the slot starting at bit 32 + k*SLOT_W, so in 8-bit mode channel 0 is bits 39..32 and channel 31 is bits 287..280.
- R2: In 8-bit mode each slot is {code[1:0], time[5:0]}, with the crossing code in the top two bits.
- R3: The window counts crossings as follows. A strobe while idle opens crossing 0, and a hit in that same cycle belongs to crossing 0. The next strobe begins crossing 1 and the one after it begins crossing 2, and a hit in a strobe cycle belongs to the crossing that strobe begins. The crossing codes are 00 for crossing 0, 01 for crossing 1 and 10 for crossing 2.
- R4: A channel with no hit in the window gets code 11 and a time field of zero.
- R5: Only the first hit of a channel within a window is kept. Later hits on that channel leave its slot unchanged.
- R6: A hit is ignored in three cases: in the cycle of the closing strobe, while idle without a strobe, and while a frame is being held.
- R7: `frame_valid` goes high in the cycle after the closing strobe. While `frame_ready` is low, it stays high and `frame_data` stays unchanged.
- R8: In the cycle after `frame_valid` and `frame_ready` are both high, `frame_valid` is low. A strobe in the accept cycle is ignored, and the next window opens at the first strobe after that cycle.
- R9: With COMPACT=1 each slot is 7 bits {flag, time[5:0]}, where flag 1 means no hit (time then zero) and flag 0 means a hit. The frame is then 256 bits.
- R10: While `rst` is high and in the cycle after it, `frame_valid` is low, and the block waits idle for an opening strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_strobe | input | 1 | Marks the first cycle of a bunch crossing |
| hit_strobe | input | NUM_CH | Per-channel hit pulse |
| hit_time | input | NUM_CH*TIME_W | Per-channel fine drift time, channel k at bits k*TIME_W upward |
| header | input | HDR_W | Header word captured when the window closes |
| frame_ready | input | 1 | Consumer accepts the held frame |
| frame_valid | output | 1 | Frame is present and held |
| frame_data | output | FRAME_W | Assembled frame (288 bits by default) |

## Verification
The timing overlap that matters most is a channel hit arriving in the same cycle as the window-closing strobe. That hit must be dropped rather than recorded as a third-crossing hit. The bench provokes this directly on a single channel, with a hit on the same channel while idle before the window opens, and expects that channel's slot to show the no-hit code. A second overlap is a crossing strobe landing in the same cycle as frame acceptance. The bench judges this from the next frame, where a hit driven between acceptance and the following strobe must not appear. Random windows with random strobe spacing repeat both overlaps many times against a model computed in the bench.

// File: rtl/drift_pkg.sv
package drift_pkg;

    // Crossing code width and window length are fixed by the slot format.
    localparam int CODE_W = 2;
    localparam int WIN_BX = 3;
    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_COLLECT,
        WS_HOLD
    } win_state_e;

    // Per-cycle control shared by every channel latch.
    typedef struct packed {
        logic              open_win;
        logic              capture;
        logic              close_win;
        logic [CODE_W-1:0] code;
    } win_ctrl_t;

    function automatic int slot_bits(input int compact, input int time_w);
        return (compact != 0) ? time_w + 1 : time_w + CODE_W;
    endfunction

endpackage

// File: rtl/bx_window_ctrl.sv
module bx_window_ctrl
    import drift_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bx_strobe,
    input  logic      frame_ready,
    output win_ctrl_t ctrl,
    output logic      frame_valid
);

    localparam logic [CODE_W-1:0] LAST_IDX = CODE_W'(WIN_BX - 1);

    win_state_e        state;
    logic [CODE_W-1:0] idx;

    always_comb begin
        ctrl      = '0;
        ctrl.code = idx;
        unique case (state)
            WS_IDLE: begin
                if (bx_strobe) begin
                    ctrl.open_win = 1'b1;
                    ctrl.capture  = 1'b1;
                    ctrl.code     = '0;
                end
            end
            WS_COLLECT: begin
                if (bx_strobe) begin
                    if (idx == LAST_IDX) begin
                        ctrl.close_win = 1'b1;
                    end else begin
                        ctrl.capture = 1'b1;
                        ctrl.code    = idx + CODE_W'(1);
                    end
                end else begin
                    ctrl.capture = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WS_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                WS_IDLE: begin
                    if (bx_strobe) begin
                        state <= WS_COLLECT;
                        idx   <= '0;
                    end
                end
                WS_COLLECT: begin
                    if (bx_strobe) begin
                        if (idx == LAST_IDX) begin
                            state <= WS_HOLD;
                        end else begin
                            idx <= idx + CODE_W'(1);
                        end
                    end
                end
                default: begin
                    if (frame_ready) begin
                        state <= WS_IDLE;
                    end
                end
            endcase
        end
    end

    assign frame_valid = (state == WS_HOLD);

endmodule

// File: rtl/hit_slot_latch.sv
module hit_slot_latch
    import drift_pkg::*;
#(
    parameter int TIME_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  win_ctrl_t         ctrl,
    input  logic              hit,
    input  logic [TIME_W-1:0] hit_time,
    output logic              seen,
    output logic [CODE_W-1:0] code,
    output logic [TIME_W-1:0] dtime
);

    // An opening strobe discards the previous window's record.
    logic take;
    assign take = ctrl.capture && hit && (ctrl.open_win || !seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            code  <= CODE_NONE;
            dtime <= '0;
        end else if (take) begin
            seen  <= 1'b1;
            code  <= ctrl.code;
            dtime <= hit_time;
        end else if (ctrl.open_win) begin
            seen  <= 1'b0;
            code  <= CODE_NONE;
            dtime <= '0;
        end
    end

endmodule

// File: rtl/frame_packer.sv
module frame_packer
    import drift_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int TIME_W  = 6,
    parameter int HDR_W   = 32,
    parameter int COMPACT = 0,
    localparam int SLOT_W  = slot_bits(COMPACT, TIME_W),
    localparam int FRAME_W = HDR_W + NUM_CH * SLOT_W
) (
    input  logic [HDR_W-1:0]         header_q,
    input  logic [NUM_CH-1:0]        seen,
    input  logic [NUM_CH*CODE_W-1:0] codes,
    input  logic [NUM_CH*TIME_W-1:0] times,
    output logic [FRAME_W-1:0]       frame
);

    assign frame[HDR_W-1:0] = header_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
        localparam int BASE = HDR_W + ch * SLOT_W;
        if (COMPACT != 0) begin : g_flag
            assign frame[BASE +: SLOT_W] = {~seen[ch], times[ch*TIME_W +: TIME_W]};
        end else begin : g_code
            assign frame[BASE +: SLOT_W] = {codes[ch*CODE_W +: CODE_W],
                                            times[ch*TIME_W +: TIME_W]};
        end
    end

endmodule

// File: rtl/drift_frame_asm.sv
module drift_frame_asm
    import drift_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int TIME_W  = 6,
    parameter int HDR_W   = 32,
    parameter int COMPACT = 0,
    localparam int SLOT_W  = slot_bits(COMPACT, TIME_W),
    localparam int FRAME_W = HDR_W + NUM_CH * SLOT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bx_strobe,
    input  logic [NUM_CH-1:0]        hit_strobe,
    input  logic [NUM_CH*TIME_W-1:0] hit_time,
    input  logic [HDR_W-1:0]         header,
    input  logic                     frame_ready,
    output logic                     frame_valid,
    output logic [FRAME_W-1:0]       frame_data
);

    win_ctrl_t                ctrl;
    logic [HDR_W-1:0]         header_q;
    logic [NUM_CH-1:0]        seen;
    logic [NUM_CH*CODE_W-1:0] codes;
    logic [NUM_CH*TIME_W-1:0] times;

    bx_window_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bx_strobe   (bx_strobe),
        .frame_ready (frame_ready),
        .ctrl        (ctrl),
        .frame_valid (frame_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            header_q <= '0;
        end else if (ctrl.close_win) begin
            header_q <= header;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        hit_slot_latch #(.TIME_W(TIME_W)) u_latch (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl),
            .hit      (hit_strobe[ch]),
            .hit_time (hit_time[ch*TIME_W +: TIME_W]),
            .seen     (seen[ch]),
            .code     (codes[ch*CODE_W +: CODE_W]),
            .dtime    (times[ch*TIME_W +: TIME_W])
        );
    end

    frame_packer #(
        .NUM_CH  (NUM_CH),
        .TIME_W  (TIME_W),
        .HDR_W   (HDR_W),
        .COMPACT (COMPACT)
    ) u_pack (
        .header_q (header_q),
        .seen     (seen),
        .codes    (codes),
        .times    (times),
        .frame    (frame_data)
    );

endmodule

// File: rtl/drift_frame_asm_chk.sv
module drift_frame_asm_chk #(
    parameter int HDR_W   = 32,
    parameter int TIME_W  = 6,
    parameter int SLOT_W  = 8,
    parameter int FRAME_W = 288,
    parameter int COMPACT = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               bx_strobe,
    input logic               frame_ready,
    input logic               frame_valid,
    input logic [FRAME_W-1:0] frame_data
);

    localparam int TOP = HDR_W + SLOT_W - 1;

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> !frame_valid);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        frame_valid && !frame_ready |=> frame_valid && $stable(frame_data));

    assert_valid_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid) |-> $past(bx_strobe));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        frame_valid && frame_ready |=> !frame_valid);

    if (COMPACT != 0) begin : g_flag_chk
        assert_nohit_time_zero_R9: assert property (@(posedge clk) disable iff (rst)
            frame_valid && frame_data[TOP] |-> frame_data[HDR_W +: TIME_W] == '0);
    end else begin : g_code_chk
        assert_nohit_time_zero_R4: assert property (@(posedge clk) disable iff (rst)
            frame_valid && frame_data[TOP -: 2] == 2'b11 |-> frame_data[HDR_W +: TIME_W] == '0);
    end

endmodule

bind drift_frame_asm drift_frame_asm_chk #(
    .HDR_W   (HDR_W),
    .TIME_W  (TIME_W),
    .SLOT_W  (SLOT_W),
    .FRAME_W (FRAME_W),
    .COMPACT (COMPACT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bx_strobe   (bx_strobe),
    .frame_ready (frame_ready),
    .frame_valid (frame_valid),
    .frame_data  (frame_data)
);

// File: tb/drift_frame_asm_bench.sv
module drift_frame_asm_bench;

    localparam int NCH = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bx_strobe = 1'b0;
    logic           frame_ready = 1'b0;
    logic [NCH-1:0] hit_strobe = '0;
    logic [NCH*6-1:0] hit_time = '0;
    logic [31:0]    header = '0;
    logic           valid_full, valid_cmp;
    logic [287:0]   frame_full;
    logic [255:0]   frame_cmp;

    always #5 clk = ~clk;

    drift_frame_asm u_drift_frame_asm (
        .clk(clk), .rst(rst), .bx_strobe(bx_strobe), .hit_strobe(hit_strobe),
        .hit_time(hit_time), .header(header), .frame_ready(frame_ready),
        .frame_valid(valid_full), .frame_data(frame_full)
    );

    drift_frame_asm #(.COMPACT(1)) u_drift_frame_asm_cmp (
        .clk(clk), .rst(rst), .bx_strobe(bx_strobe), .hit_strobe(hit_strobe),
        .hit_time(hit_time), .header(header), .frame_ready(frame_ready),
        .frame_valid(valid_cmp), .frame_data(frame_cmp)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench model of the window, built from the requirements.
    bit         m_seen [NCH];
    logic [1:0] m_code [NCH];
    logic [5:0] m_time [NCH];
    int         m_phase = -1;   // -1 idle, 0..2 crossing, -2 holding
    logic [31:0] m_hdr = '0;

    function automatic logic [287:0] exp_full();
        logic [287:0] r;
        r[31:0] = m_hdr;
        for (int ch = 0; ch < NCH; ch++)
            r[32 + 8*ch +: 8] = m_seen[ch] ? {m_code[ch], m_time[ch]} : 8'hC0;
        return r;
    endfunction

    function automatic logic [255:0] exp_cmp();
        logic [255:0] r;
        r[31:0] = m_hdr;
        for (int ch = 0; ch < NCH; ch++)
            r[32 + 7*ch +: 7] = m_seen[ch] ? {1'b0, m_time[ch]} : 7'h40;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [287:0] act, input logic [287:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic capture(input int code, input logic [NCH-1:0] hv);
        for (int ch = 0; ch < NCH; ch++) begin
            if (hv[ch] && !m_seen[ch]) begin
                m_seen[ch] = 1'b1;
                m_code[ch] = 2'(code);
                m_time[ch] = hit_time[ch*6 +: 6];
            end
        end
    endtask

    // Drive one cycle at the falling edge, update the model, advance.
    task automatic step(input bit s, input logic [NCH-1:0] hv, input bit rdy);
        bx_strobe   = s;
        hit_strobe  = hv;
        frame_ready = rdy;
        header      = $urandom;
        for (int ch = 0; ch < NCH; ch++) hit_time[ch*6 +: 6] = 6'($urandom_range(0, 63));
        if (m_phase == -1) begin
            if (s) begin
                for (int ch = 0; ch < NCH; ch++) m_seen[ch] = 1'b0;
                m_phase = 0;
                capture(0, hv);
            end
        end else if (m_phase >= 0) begin
            if (s && m_phase == 2) begin
                m_hdr   = header;
                m_phase = -2;
            end else begin
                if (s) m_phase++;
                capture(m_phase, hv);
            end
        end else if (rdy) begin
            m_phase = -1;
        end
        @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] rnd_hits();
        return $urandom & $urandom;
    endfunction

    task automatic check_frame(input string tag);
        chk(valid_full && valid_cmp, "R7", {tag, " valid after close"},
            288'({valid_full, valid_cmp}), 288'(2'b11));
        chk(frame_full[31:0] === m_hdr, "R1", {tag, " header"},
            288'(frame_full[31:0]), 288'(m_hdr));
        chk(frame_full === exp_full(), "R2 R3", {tag, " 8-bit frame"}, frame_full, exp_full());
        chk(frame_cmp === exp_cmp(), "R9", {tag, " 7-bit frame"}, 288'(frame_cmp), 288'(exp_cmp()));
    endtask

    task automatic finish_frame(input int hold, input bit strobe_acc);
        for (int i = 0; i < hold; i++) begin
            step(bit'($urandom_range(0, 1)), rnd_hits(), 1'b0);
            chk(valid_full && frame_full === exp_full(), "R7 R6", "held frame",
                frame_full, exp_full());
        end
        step(strobe_acc, rnd_hits(), 1'b1);
        chk(!valid_full && !valid_cmp, "R8", "valid drops after accept",
            288'({valid_full, valid_cmp}), 288'(0));
        if (strobe_acc) step(1'b0, rnd_hits(), 1'b0);
    endtask

    task automatic rand_window();
        repeat ($urandom_range(0, 3)) step(1'b0, rnd_hits(), 1'b0);
        step(1'b1, rnd_hits(), 1'b0);
        for (int k = 0; k < 3; k++) begin
            repeat ($urandom_range(0, 3)) step(1'b0, rnd_hits(), 1'b0);
            step(1'b1, rnd_hits(), 1'b0);
        end
        check_frame("random");
        finish_frame($urandom_range(0, 2), bit'($urandom_range(0, 1)));
    endtask

    initial begin
        logic [5:0] t_first;
        void'($urandom(32'd2024));
        for (int ch = 0; ch < NCH; ch++) begin
            m_seen[ch] = 1'b0; m_code[ch] = 2'b11; m_time[ch] = '0;
        end
        repeat (3) @(negedge clk);
        chk(!valid_full && !valid_cmp, "R10", "valid low in reset",
            288'({valid_full, valid_cmp}), 288'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(!valid_full, "R10", "valid low after reset", 288'(valid_full), 288'(0));

        // R4: empty window
        step(1'b1, '0, 1'b0); step(1'b0, '0, 1'b0);
        step(1'b1, '0, 1'b0); step(1'b1, '0, 1'b0); step(1'b1, '0, 1'b0);
        chk(frame_full[39:32] === 8'hC0, "R4", "no-hit slot ch0",
            288'(frame_full[39:32]), 288'(8'hC0));
        chk(frame_cmp[38:32] === 7'h40, "R9", "no-hit flag ch0",
            288'(frame_cmp[38:32]), 288'(7'h40));
        check_frame("empty");
        finish_frame(2, 1'b0);

        // R3 and R5: crossing codes and first-hit retention
        step(1'b1, 32'h0000_0008, 1'b0);          // ch3 in opening cycle
        step(1'b0, 32'h0000_0020, 1'b0);          // ch5 first hit, crossing 0
        t_first = m_time[5];
        step(1'b1, 32'h0000_0200, 1'b0);          // ch9 at start of crossing 1
        step(1'b0, '0, 1'b0);
        step(1'b1, 32'h0000_0020, 1'b0);          // ch5 again, crossing 2
        step(1'b0, 32'h0000_0420, 1'b0);          // ch10 crossing 2, ch5 again
        step(1'b1, '0, 1'b0);
        chk(frame_full[32+8*3 +: 8] === {2'b00, m_time[3]}, "R3", "opening-cycle hit code 00",
            288'(frame_full[32+8*3 +: 8]), 288'({2'b00, m_time[3]}));
        chk(frame_full[32+8*9 +: 2*4] === {2'b01, m_time[9]}, "R3", "crossing 1 code 01",
            288'(frame_full[32+8*9 +: 8]), 288'({2'b01, m_time[9]}));
        chk(frame_full[32+8*10 +: 8] === {2'b10, m_time[10]}, "R3", "crossing 2 code 10",
            288'(frame_full[32+8*10 +: 8]), 288'({2'b10, m_time[10]}));
        chk(frame_full[32+8*5 +: 8] === {2'b00, t_first}, "R5", "first hit kept",
            288'(frame_full[32+8*5 +: 8]), 288'({2'b00, t_first}));
        check_frame("codes");
        finish_frame(1, 1'b1);

        // R6: hit while idle and hit in the closing-strobe cycle
        step(1'b0, 32'h0000_0080, 1'b0);
        step(1'b1, '0, 1'b0); step(1'b1, '0, 1'b0); step(1'b1, '0, 1'b0);
        step(1'b1, 32'h0000_0080, 1'b0);
        chk(frame_full[32+8*7 +: 8] === 8'hC0, "R6", "closing-cycle hit dropped",
            288'(frame_full[32+8*7 +: 8]), 288'(8'hC0));
        check_frame("close-hit");
        finish_frame(3, 1'b1);

        for (int n = 0; n < 40; n++) rand_window();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule